// File: doc/BRIEF.md
# Banded Framebuffer Refresh Engine

This block pushes one band of a 128-column by 64-row monochrome frame to a graphics LCD controller over a write-only serial link. A band covers 16 pixel rows. It sits in a 256-byte band buffer as two 128-byte halves, and each byte holds 8 vertical pixels of one column. The controller stores the panel as pages of 8 rows, so each band fills two consecutive controller pages. Band n fills pages 2n and 2n+1.

After a one-cycle `band_start` pulse with a band index of 0 to 3, the engine does the following for each of the two pages in order:
- It drops chip-select.
- With the data/command line low, it sends the column-address reset pair and then the page-select command.
- It raises the data/command line and streams the 128 buffer bytes of that half.
- It holds chip-select low for a settling pause.
- It releases chip-select.

The buffer is read through a synchronous port with one cycle of read latency. The engine issues each address one cycle before it needs the byte. When the second page has finished, `band_done` pulses for one cycle.

Top module: `band_refresh`

## Requirements
- R1: After reset, and until a transfer starts, `lcd_cs_n` is 1, `lcd_sck` is 0, `band_done` is 0 and `rd_en` is 0.
- R2: Each page transfer begins, with `lcd_dc` = 0, with the command bytes 0x10 and then 0x00, which set the controller column address to zero.
- R3: The third command byte of a page is 0xB0 OR the page number. For band n (0 to 3) the first page is 2n and the second is 2n+1.
- R4: After the page command, `lcd_dc` = 1 and exactly 128 data bytes follow. The first page carries buffer bytes 0 to 127 in address order, and the second page carries bytes 128 to 255.
- R5: Bytes go out MSB first on `lcd_mosi`. The receiver samples on the rising edge of `lcd_sck`. `lcd_mosi` changes only while `lcd_sck` is low, `lcd_sck` idles low, and every rising edge happens with `lcd_cs_n` = 0.
- R6: Between the two pages, `lcd_cs_n` goes high for exactly CSIDLE_CLKS cycles. It goes high again at the end of the band, so there are two rising edges per band.
- R7: After the last data bit of a page, `lcd_cs_n` stays low for at least GAP_CLKS cycles before it rises.
- R8: `band_done` is high for exactly one cycle per band. That cycle is the first cycle with `lcd_cs_n` high after the second page.
- R9: A `band_start` that arrives while a band is in progress is ignored. The running band keeps its pages and data, and no extra band follows.
- R10: A `band_start` that arrives in the same cycle as `band_done` is accepted and begins a new band.
- R11: `rd_en` is asserted only while `lcd_dc` = 1. Per band, it is asserted 256 times with addresses 0 to 255 in increasing order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| band_start | input | 1 | One-cycle request to transfer a band |
| band_idx | input | 2 | Band number (0 to 3), captured with an accepted `band_start` |
| band_done | output | 1 | One-cycle pulse when the band is complete |
| rd_en | output | 1 | Band buffer read enable |
| rd_addr | output | 8 | Band buffer read address; bit 7 selects the half |
| rd_data | input | 8 | Band buffer read data, valid one cycle after `rd_en` |
| lcd_cs_n | output | 1 | Controller chip-select, active low |
| lcd_sck | output | 1 | Serial clock, idle low |
| lcd_mosi | output | 1 | Serial data, MSB first |
| lcd_dc | output | 1 | 0 = command byte, 1 = pixel data byte |

## Verification
The two functions that can share a cycle are the end-of-band report and the acceptance of a new request. In the cycle `band_done` is high, the engine is already idle and must take a fresh `band_start`. The bench raises `band_start` at the falling edge where it first sees `band_done`, so the next rising edge sees both signals together. It then judges the captured serial stream: both bands must appear complete and back to back, with the second band's page numbers, four chip-select releases and two done pulses. As a contrast, a request injected halfway through a band must leave that band's stream unchanged and must not start another band.

// File: rtl/bandref_pkg.sv
package bandref_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_CMD, ST_CMDW, ST_LOAD, ST_DAT, ST_DATW, ST_GAP, ST_CSH
   } bref_state_t;

   localparam logic [7:0] COL_HI_ZERO = 8'h10;
   localparam logic [7:0] COL_LO_ZERO = 8'h00;
   localparam logic [3:0] PAGE_OPC    = 4'hB;
   localparam int         CMD_BYTES   = 3;

   function automatic logic [7:0] page_cmd(input logic [3:0] page);
      return {PAGE_OPC, page};
   endfunction
endpackage

// File: rtl/bref_shifter.sv
module bref_shifter #(
   parameter int HALF_CLKS = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] byte_in,
   output logic       done,
   output logic       sck,
   output logic       mosi
);
   logic       busy, ph, tick;
   logic [2:0] bitc;
   logic [7:0] sh;

   generate
      if (HALF_CLKS > 1) begin : g_div
         localparam int DW = $clog2(HALF_CLKS);
         logic [DW-1:0] dcnt;
         assign tick = busy && (dcnt == DW'(HALF_CLKS - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               dcnt <= '0;
            else if (!busy || tick)   dcnt <= '0;
            else                      dcnt <= dcnt + DW'(1);
         end
      end else begin : g_nodiv
         assign tick = busy;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         ph   <= 1'b0;
         bitc <= '0;
         sh   <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy <= 1'b1;
               sh   <= byte_in;
               ph   <= 1'b0;
               bitc <= '0;
            end
         end else if (tick) begin
            if (!ph) begin
               ph <= 1'b1;
            end else begin
               ph <= 1'b0;
               if (bitc == 3'd7) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  bitc <= bitc + 3'd1;
                  sh   <= {sh[6:0], 1'b0};
               end
            end
         end
      end
   end

   assign sck  = busy & ph;
   assign mosi = sh[7];
endmodule

// File: rtl/bref_timer.sv
module bref_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] val,
   output logic          expired
);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= val;
      else if (cnt != '0)    cnt <= cnt - TW'(1);
   end

   assign expired = (cnt == TW'(1));
endmodule

// File: rtl/bref_seq.sv
module bref_seq
   import bandref_pkg::*;
#(
   parameter int COLS        = 128,
   parameter int PPB         = 2,
   parameter int BW          = 2,
   parameter int CW          = 7,
   parameter int PGW         = 1,
   parameter int AW          = 8,
   parameter int TW          = 8,
   parameter int GAP_CLKS    = 2500,
   parameter int CSIDLE_CLKS = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          band_start,
   input  logic [BW-1:0] band_idx,
   output logic          band_done,
   output logic          rd_en,
   output logic [AW-1:0] rd_addr,
   input  logic [7:0]    rd_data,
   output logic          sh_start,
   output logic [7:0]    sh_byte,
   input  logic          sh_done,
   output logic          tmr_load,
   output logic [TW-1:0] tmr_val,
   input  logic          tmr_exp,
   output logic          cs_n,
   output logic          dc
);
   localparam logic [CW-1:0]  LASTCOL = CW'(COLS - 1);
   localparam logic [PGW-1:0] LASTPG  = PGW'(PPB - 1);

   bref_state_t    st;
   logic [1:0]     ci;
   logic [CW-1:0]  col;
   logic [PGW-1:0] pg;
   logic [BW-1:0]  band_q;
   logic [3:0]     page_no;
   logic [7:0]     cmd_byte;

   assign page_no = 4'(band_q) * 4'(PPB) + 4'(pg);

   always_comb begin
      case (ci)
         2'd0:    cmd_byte = COL_HI_ZERO;
         2'd1:    cmd_byte = COL_LO_ZERO;
         default: cmd_byte = page_cmd(page_no);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         ci        <= '0;
         col       <= '0;
         pg        <= '0;
         band_q    <= '0;
         band_done <= 1'b0;
      end else begin
         band_done <= 1'b0;
         case (st)
            ST_IDLE: if (band_start) begin
               band_q <= band_idx;
               pg     <= '0;
               ci     <= '0;
               st     <= ST_CMD;
            end
            ST_CMD:  st <= ST_CMDW;
            ST_CMDW: if (sh_done) begin
               if (ci == 2'(CMD_BYTES - 1)) begin
                  ci  <= '0;
                  col <= '0;
                  st  <= ST_LOAD;
               end else begin
                  ci <= ci + 2'd1;
                  st <= ST_CMD;
               end
            end
            ST_LOAD: st <= ST_DAT;
            ST_DAT:  st <= ST_DATW;
            ST_DATW: if (sh_done) begin
               if (col == LASTCOL) st <= ST_GAP;
               else begin
                  col <= col + CW'(1);
                  st  <= ST_DAT;
               end
            end
            ST_GAP: if (tmr_exp) begin
               if (pg == LASTPG) begin
                  st        <= ST_IDLE;
                  band_done <= 1'b1;
               end else st <= ST_CSH;
            end
            ST_CSH: if (tmr_exp) begin
               pg <= pg + PGW'(1);
               st <= ST_CMD;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      sh_start = 1'b0;
      sh_byte  = 8'h00;
      rd_en    = 1'b0;
      rd_addr  = '0;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (st)
         ST_CMD: begin
            sh_start = 1'b1;
            sh_byte  = cmd_byte;
         end
         ST_LOAD: begin
            rd_en   = 1'b1;
            rd_addr = {pg, CW'(0)};
         end
         ST_DAT: begin
            sh_start = 1'b1;
            sh_byte  = rd_data;
            if (col != LASTCOL) begin
               rd_en   = 1'b1;
               rd_addr = {pg, col + CW'(1)};
            end
         end
         ST_DATW: if (sh_done && col == LASTCOL) begin
            tmr_load = 1'b1;
            tmr_val  = TW'(GAP_CLKS);
         end
         ST_GAP: if (tmr_exp && pg != LASTPG) begin
            tmr_load = 1'b1;
            tmr_val  = TW'(CSIDLE_CLKS);
         end
         default: ;
      endcase
   end

   assign cs_n = (st == ST_IDLE) || (st == ST_CSH);
   assign dc   = (st == ST_LOAD) || (st == ST_DAT) || (st == ST_DATW) || (st == ST_GAP);
endmodule

// File: rtl/band_refresh.sv
module band_refresh #(
   parameter int COLS        = 128,
   parameter int ROWS        = 64,
   parameter int BAND_ROWS   = 16,
   parameter int PAGE_ROWS   = 8,
   parameter int HALF_CLKS   = 2,
   parameter int GAP_CLKS    = 2500,
   parameter int CSIDLE_CLKS = 4,
   localparam int BANDS = ROWS / BAND_ROWS,
   localparam int PPB   = BAND_ROWS / PAGE_ROWS,
   localparam int BW    = (BANDS > 1) ? $clog2(BANDS) : 1,
   localparam int CW    = $clog2(COLS),
   localparam int PGW   = (PPB > 1) ? $clog2(PPB) : 1,
   localparam int AW    = PGW + CW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          band_start,
   input  logic [BW-1:0] band_idx,
   output logic          band_done,
   output logic          rd_en,
   output logic [AW-1:0] rd_addr,
   input  logic [7:0]    rd_data,
   output logic          lcd_cs_n,
   output logic          lcd_sck,
   output logic          lcd_mosi,
   output logic          lcd_dc
);
   localparam int TMAX = (GAP_CLKS > CSIDLE_CLKS) ? GAP_CLKS : CSIDLE_CLKS;
   localparam int TW   = $clog2(TMAX + 1);

   generate
      if (ROWS % BAND_ROWS != 0 || BAND_ROWS % PAGE_ROWS != 0) begin : g_bad_geom
         $error("band_refresh: rows must split evenly into bands and pages");
      end
      if (PPB != (1 << PGW) || PPB < 2) begin : g_bad_ppb
         $error("band_refresh: pages per band must be a power of two, at least 2");
      end
      if (COLS != (1 << CW)) begin : g_bad_cols
         $error("band_refresh: column count must be a power of two");
      end
      if (ROWS / PAGE_ROWS > 16) begin : g_bad_pages
         $error("band_refresh: page number must fit the 4-bit page command field");
      end
      if (HALF_CLKS < 1 || GAP_CLKS < 1 || CSIDLE_CLKS < 1) begin : g_bad_time
         $error("band_refresh: timing parameters must be at least 1");
      end
   endgenerate

   logic          sh_start, sh_done;
   logic [7:0]    sh_byte;
   logic          tmr_load, tmr_exp;
   logic [TW-1:0] tmr_val;

   bref_seq #(
      .COLS(COLS), .PPB(PPB), .BW(BW), .CW(CW), .PGW(PGW), .AW(AW), .TW(TW),
      .GAP_CLKS(GAP_CLKS), .CSIDLE_CLKS(CSIDLE_CLKS)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .band_start(band_start), .band_idx(band_idx),
      .band_done(band_done), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .sh_start(sh_start), .sh_byte(sh_byte), .sh_done(sh_done),
      .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_exp(tmr_exp),
      .cs_n(lcd_cs_n), .dc(lcd_dc)
   );

   bref_shifter #(.HALF_CLKS(HALF_CLKS)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(sh_start), .byte_in(sh_byte),
      .done(sh_done), .sck(lcd_sck), .mosi(lcd_mosi)
   );

   bref_timer #(.TW(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .expired(tmr_exp)
   );
endmodule

// File: rtl/bref_chk.sv
module bref_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic sck,
   input logic mosi,
   input logic dc,
   input logic rd_en,
   input logic band_done
);
   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      band_done |=> !band_done);

   p_done_cs_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      band_done |-> cs_n);

   p_clk_needs_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sck |-> !cs_n);

   p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(mosi));

   p_read_in_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> dc);

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (!sck && !rd_en));
endmodule

bind band_refresh bref_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(lcd_cs_n), .sck(lcd_sck), .mosi(lcd_mosi),
   .dc(lcd_dc), .rd_en(rd_en), .band_done(band_done)
);

// File: tb/sim_band_refresh.sv
module sim_band_refresh;
   localparam int COLS   = 128;
   localparam int HALF   = 1;
   localparam int GAP    = 40;
   localparam int CSIDLE = 5;
   localparam int BYTES_PER_BAND = 2 * (3 + COLS);

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       band_start = 1'b0;
   logic [1:0] band_idx = '0;
   logic       band_done, rd_en;
   logic [7:0] rd_addr, rd_data;
   logic       lcd_cs_n, lcd_sck, lcd_mosi, lcd_dc;

   always #2 clk = ~clk;

   band_refresh #(
      .COLS(COLS), .HALF_CLKS(HALF), .GAP_CLKS(GAP), .CSIDLE_CLKS(CSIDLE)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .band_start(band_start), .band_idx(band_idx),
      .band_done(band_done), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .lcd_cs_n(lcd_cs_n), .lcd_sck(lcd_sck), .lcd_mosi(lcd_mosi), .lcd_dc(lcd_dc)
   );

   logic [7:0] mem [0:255];
   always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

   int errors = 0;
   int checks = 0;

   // serial capture
   logic       cap_clr = 1'b0;
   logic [7:0] cap_b [0:1023];
   logic       cap_dc [0:1023];
   int cap_n, bitn, viol, cs_rises, min_gap, since_rise, run, mid_cnt, mid_bad;
   int done_cnt, rd_cnt, rd_bad, rd_exp;
   logic [7:0] shv;
   logic psck = 1'b0, pmosi = 1'b0, pcs = 1'b1;

   always @(negedge clk) begin
      if (cap_clr) begin
         cap_n = 0; bitn = 0; viol = 0; cs_rises = 0; min_gap = 1000000;
         since_rise = 0; run = 0; mid_cnt = 0; mid_bad = 0; done_cnt = 0;
         rd_cnt = 0; rd_bad = 0; rd_exp = 0; shv = '0;
      end else if (rst_n) begin
         if (lcd_sck && !psck) begin
            if (lcd_cs_n) viol++;
            shv = {shv[6:0], lcd_mosi};
            bitn++;
            since_rise = 0;
            if (bitn == 8) begin
               if (cap_n < 1024) begin
                  cap_b[cap_n] = shv;
                  cap_dc[cap_n] = lcd_dc;
               end
               cap_n++;
               bitn = 0;
            end
         end else since_rise++;
         if (lcd_sck && psck && (lcd_mosi != pmosi)) viol++;
         if (lcd_cs_n && !pcs) begin
            cs_rises++;
            if (since_rise < min_gap) min_gap = since_rise;
         end
         if (lcd_cs_n) begin
            run++;
            bitn = 0;
         end else begin
            if (pcs && (cs_rises % 2 == 1)) begin
               mid_cnt++;
               if (run != CSIDLE) mid_bad++;
            end
            run = 0;
         end
         if (band_done) done_cnt++;
         if (rd_en) begin
            if (rd_addr != rd_exp[7:0]) rd_bad++;
            rd_exp++;
            rd_cnt++;
         end
      end
      psck = lcd_sck; pmosi = lcd_mosi; pcs = lcd_cs_n;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   task automatic fill(input int pat);
      for (int a = 0; a < 256; a++) begin
         case (pat)
            0: mem[a] = 8'(a) ^ 8'h5A;
            1: mem[a] = a[0] ? 8'h01 : 8'h80;
            2: mem[a] = 8'(255 - a);
            default: mem[a] = 8'(a * 7 + 3);
         endcase
      end
   endtask

   task automatic clear_cap();
      @(negedge clk) cap_clr = 1'b1;
      @(negedge clk) cap_clr = 1'b0;
   endtask

   task automatic pulse_start(input int n);
      @(negedge clk);
      band_idx = 2'(n);
      band_start = 1'b1;
      @(negedge clk);
      band_start = 1'b0;
   endtask

   task automatic wait_done(output bit seen);
      seen = 1'b0;
      for (int i = 0; i < 30000; i++) begin
         @(negedge clk);
         if (band_done) begin
            seen = 1'b1;
            break;
         end
      end
      chk(seen, "R8 band_done within timeout", 0, 1);
   endtask

   // checks one band's bytes in the capture starting at byte offset off
   task automatic check_stream(input int n, input int off, input string tag);
      int bad_cmd, bad_pg, bad_dat, act_pg;
      bad_cmd = 0; bad_pg = 0; bad_dat = 0; act_pg = 0;
      for (int p = 0; p < 2; p++) begin
         int b;
         b = off + p * (3 + COLS);
         if (cap_b[b] != 8'h10 || cap_b[b+1] != 8'h00 || cap_dc[b] || cap_dc[b+1]) bad_cmd++;
         if (cap_b[b+2] != (8'hB0 | 8'(2*n + p)) || cap_dc[b+2]) begin
            bad_pg++;
            act_pg = cap_b[b+2];
         end
         for (int c = 0; c < COLS; c++)
            if (cap_b[b+3+c] != mem[p*COLS + c] || !cap_dc[b+3+c]) bad_dat++;
      end
      chk(bad_cmd == 0, {"R2 column reset commands ", tag}, bad_cmd, 0);
      chk(bad_pg == 0, {"R3 page commands ", tag}, act_pg, 8'hB0 | 8'(2*n));
      chk(bad_dat == 0, {"R4/R5 data bytes MSB first ", tag}, bad_dat, 0);
   endtask

   task automatic check_band_timing(input int bands, input string tag);
      chk(cap_n == bands * BYTES_PER_BAND, {"R4 byte count ", tag}, cap_n, bands * BYTES_PER_BAND);
      chk(viol == 0, {"R5 clock/data/select discipline ", tag}, viol, 0);
      chk(cs_rises == 2 * bands, {"R6 select releases ", tag}, cs_rises, 2 * bands);
      chk(mid_cnt == bands && mid_bad == 0, {"R6 inter-page select high time ", tag}, mid_bad, 0);
      chk(min_gap >= GAP, {"R7 pause after last byte ", tag}, min_gap, GAP);
      chk(done_cnt == bands, {"R8 done pulse count ", tag}, done_cnt, bands);
      chk(rd_cnt == 256 * bands && rd_bad == 0, {"R11 read sequence ", tag}, rd_cnt, 256 * bands);
   endtask

   task automatic t_reset();
      chk(lcd_cs_n && !lcd_sck && !band_done && !rd_en, "R1 outputs in reset",
          {lcd_cs_n, lcd_sck, band_done, rd_en}, 4'b1000);
      @(negedge clk) rst_n = 1'b1;
      repeat (10) @(negedge clk);
      chk(lcd_cs_n && !lcd_sck && !band_done && !rd_en, "R1 idle after reset",
          {lcd_cs_n, lcd_sck, band_done, rd_en}, 4'b1000);
   endtask

   task automatic t_band(input int n, input int pat);
      bit seen;
      string tag;
      tag = $sformatf("band%0d", n);
      fill(pat);
      clear_cap();
      pulse_start(n);
      wait_done(seen);
      repeat (4) @(negedge clk);
      check_stream(n, 0, tag);
      check_band_timing(1, tag);
   endtask

   task automatic t_ignore_busy();
      bit seen;
      fill(2);
      clear_cap();
      pulse_start(1);
      repeat (600) @(negedge clk);
      band_idx = 2'd2;
      band_start = 1'b1;
      @(negedge clk) band_start = 1'b0;
      wait_done(seen);
      repeat (200) @(negedge clk);
      check_stream(1, 0, "R9 busy start");
      chk(cap_n == BYTES_PER_BAND && done_cnt == 1 && lcd_cs_n,
          "R9 no extra band after mid-band start", cap_n, BYTES_PER_BAND);
   endtask

   task automatic t_start_on_done();
      bit seen;
      fill(3);
      clear_cap();
      pulse_start(3);
      wait_done(seen);
      // band_done is high now; the next rising edge sees both
      band_idx = 2'd0;
      band_start = 1'b1;
      @(negedge clk) band_start = 1'b0;
      chk(!lcd_cs_n, "R10 start in done cycle accepted", lcd_cs_n, 0);
      wait_done(seen);
      repeat (4) @(negedge clk);
      check_stream(3, 0, "R10 first");
      check_stream(0, BYTES_PER_BAND, "R10 second");
      check_band_timing(2, "R10 pair");
   endtask

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      t_band(0, 0);
      t_band(3, 1);
      t_band(2, 2);
      t_ignore_busy();
      t_start_on_done();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule